// File: doc/BRIEF.md
# Fast Row Programming Monitor

This block supervises a streaming row-program mode of an embedded flash controller. While the fast-program enable is high, software or a DMA engine feeds double-word writes that must all land in a single flash row, in strictly ascending order. For each double word, the array returns a completion pulse. The monitor checks every write against the row and the ordering rules, and it watches for the data stream running dry. It times how long the enable has been held, using a slow tick, and it notices when other parts of the controller report an interrupting error. When any of these rules is broken, it raises a fast-programming error and pulses a row-abort strobe. A starved stream also raises a separate data-miss error.

Addresses are double-word indices. The low log2(ROW_DW) bits select the double word inside a row, and the bits above them select the row. The first write after the enable rises sets the row base and is always accepted. Once an error has been raised, the monitor stops tracking the row and ignores further data. Both error flags stay set until the enable is dropped.

Top module: `fast_row_monitor`

## Requirements
- R1: After reset, fastErr, missErr and rowAbort are all 0.
- R2: The first write after fastEn goes high is accepted for any address without raising an error.
- R3: A write whose address bits above the row-offset field differ from those of the first write in the row sets fastErr at the next clock edge.
- R4: A write whose address is equal to or lower than the previous accepted address sets fastErr at the next clock edge.
- R5: If progDone arrives with exactly one accepted double word outstanding, no write in the same cycle, and fewer than ROW_DW words accepted in the row, both missErr and fastErr are set at the next clock edge.
- R6: A progDone that arrives after ROW_DW words have been accepted raises no error.
- R7: With fastEn held, the (TIMEOUT_TICKS+1)th msTick sets fastErr; the TIMEOUT_TICKS-th tick does not.
- R8: Any bit of intrErr that is high while fastEn is high sets fastErr at the next clock edge.
- R9: rowAbort is a one-cycle pulse, raised at the same edge at which fastErr first becomes set for the row.
- R10: After an error, fastErr stays set while fastEn remains high. Writes and completions in that period cause no missErr and no further rowAbort.
- R11: Dropping fastEn clears both flags at the next edge and restarts the tick timer and the row state.
- R12: Writes, completions and intrErr while fastEn is low have no effect. The next write after fastEn rises is treated as the row base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| fastEn | input | 1 | Fast row-program enable |
| wrValid | input | 1 | Double-word write strobe |
| wrAddr | input | ADDR_W | Double-word address of the write |
| progDone | input | 1 | Array finished programming one double word |
| msTick | input | 1 | Single-cycle timing tick |
| intrErr | input | INTR_W | Interrupting errors from other checkers (alignment, protection, size) |
| fastErr | output | 1 | Fast-programming error, sticky while enabled |
| missErr | output | 1 | Data-miss error, sticky while enabled |
| rowAbort | output | 1 | One-cycle strobe telling the array to abandon the row |

## Verification
The bench builds the monitor with ROW_DW=4, ADDR_W=8 and TIMEOUT_TICKS=3. A four-word row lets a complete row run to its end, so the final completion can be shown not to count as a miss. A three-tick limit brings the timeout boundary, and the restart of the timer after the enable drops, within a handful of cycles. With 8-bit addresses, crossing a row and re-using or going back to an address take only a few literal values.

// File: rtl/fast_row_pkg.sv
package fast_row_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_LOCK = 2'd2
  } monState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;
    logic latchBase;
    logic advance;
    logic tickEn;
  } dpStrobe_t;

  // comparisons from datapath to control
  typedef struct packed {
    logic rowMismatch;
    logic notIncreasing;
    logic missCond;
    logic timeoutHit;
  } dpStatus_t;

endpackage

// File: rtl/fast_row_datapath.sv
module fast_row_datapath
  import fast_row_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int ROW_DW        = 32,
  parameter int TIMEOUT_TICKS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              progDone,
  output dpStatus_t         status
);

  localparam int OFF_W = $clog2(ROW_DW);
  localparam int ROW_W = ADDR_W - OFF_W;
  localparam int CNT_W = $clog2(ROW_DW + 1);
  localparam int TCK_W = $clog2(TIMEOUT_TICKS + 2);
  localparam logic [CNT_W-1:0] ROW_FULL  = CNT_W'(ROW_DW);
  localparam logic [TCK_W-1:0] TICK_LAST = TCK_W'(TIMEOUT_TICKS);
  localparam logic [TCK_W-1:0] TICK_SAT  = TCK_W'(TIMEOUT_TICKS + 1);

  logic [ROW_W-1:0]  baseRow;
  logic [ADDR_W-1:0] lastAddr;
  logic [CNT_W-1:0]  wrCount;
  logic [CNT_W-1:0]  pending;
  logic [TCK_W-1:0]  tickCount;
  logic              doneDec;

  assign doneDec = progDone && (pending != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseRow  <= '0;
      lastAddr <= '0;
      wrCount  <= '0;
      pending  <= '0;
    end else if (strobe.clear) begin
      baseRow  <= '0;
      lastAddr <= '0;
      wrCount  <= '0;
      pending  <= '0;
    end else if (strobe.latchBase) begin
      baseRow  <= wrAddr[ADDR_W-1:OFF_W];
      lastAddr <= wrAddr;
      wrCount  <= CNT_W'(1);
      pending  <= CNT_W'(1);
    end else if (strobe.advance) begin
      lastAddr <= wrAddr;
      wrCount  <= wrCount + CNT_W'(1);
      pending  <= pending + CNT_W'(1) - CNT_W'(doneDec);
    end else if (doneDec) begin
      pending  <= pending - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCount <= '0;
    end else if (strobe.clear) begin
      tickCount <= '0;
    end else if (strobe.tickEn && tickCount != TICK_SAT) begin
      tickCount <= tickCount + TCK_W'(1);
    end
  end

  always_comb begin
    status.rowMismatch   = wrAddr[ADDR_W-1:OFF_W] != baseRow;
    status.notIncreasing = wrAddr <= lastAddr;
    status.missCond      = progDone && !wrValid &&
                           (pending == CNT_W'(1)) && (wrCount < ROW_FULL);
    status.timeoutHit    = strobe.tickEn && (tickCount == TICK_LAST);
  end

endmodule

// File: rtl/fast_row_control.sv
module fast_row_control
  import fast_row_pkg::*;
#(
  parameter int INTR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fastEn,
  input  logic              wrValid,
  input  logic              msTick,
  input  logic [INTR_W-1:0] intrErr,
  input  dpStatus_t         status,
  output dpStrobe_t         strobe,
  output logic              fastErr,
  output logic              missErr,
  output logic              rowAbort
);

  monState_t state, stateNext;
  logic      watching;
  logic      errSeq, errMiss, errTime, errIntr, anyErr;

  assign watching = fastEn && (state != ST_LOCK);

  always_comb begin
    errSeq  = watching && wrValid && (state == ST_RUN) &&
              (status.rowMismatch || status.notIncreasing);
    errMiss = watching && (state == ST_RUN) && status.missCond;
    errTime = watching && status.timeoutHit;
    errIntr = watching && (|intrErr);
    anyErr  = errSeq || errMiss || errTime || errIntr;
  end

  always_comb begin
    strobe.clear     = !fastEn;
    strobe.tickEn    = fastEn && msTick;
    strobe.latchBase = watching && (state == ST_IDLE) && wrValid && !anyErr;
    strobe.advance   = watching && (state == ST_RUN) && wrValid && !anyErr;
  end

  always_comb begin
    stateNext = state;
    if (!fastEn) begin
      stateNext = ST_IDLE;
    end else if (anyErr) begin
      stateNext = ST_LOCK;
    end else if (state == ST_IDLE && wrValid) begin
      stateNext = ST_RUN;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      fastErr  <= 1'b0;
      missErr  <= 1'b0;
      rowAbort <= 1'b0;
    end else begin
      state    <= stateNext;
      rowAbort <= anyErr;
      if (!fastEn) begin
        fastErr <= 1'b0;
        missErr <= 1'b0;
      end else begin
        if (anyErr)  fastErr <= 1'b1;
        if (errMiss) missErr <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/fast_row_monitor.sv
module fast_row_monitor
  import fast_row_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int ROW_DW        = 32,
  parameter int TIMEOUT_TICKS = 8,
  parameter int INTR_W        = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fastEn,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              progDone,
  input  logic              msTick,
  input  logic [INTR_W-1:0] intrErr,
  output logic              fastErr,
  output logic              missErr,
  output logic              rowAbort
);

  dpStrobe_t strobe;
  dpStatus_t status;

  fast_row_datapath #(
    .ADDR_W        (ADDR_W),
    .ROW_DW        (ROW_DW),
    .TIMEOUT_TICKS (TIMEOUT_TICKS)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrValid  (wrValid),
    .wrAddr   (wrAddr),
    .progDone (progDone),
    .status   (status)
  );

  fast_row_control #(
    .INTR_W (INTR_W)
  ) u_control (
    .clk      (clk),
    .rstN     (rstN),
    .fastEn   (fastEn),
    .wrValid  (wrValid),
    .msTick   (msTick),
    .intrErr  (intrErr),
    .status   (status),
    .strobe   (strobe),
    .fastErr  (fastErr),
    .missErr  (missErr),
    .rowAbort (rowAbort)
  );

endmodule

// File: rtl/fast_row_monitor_checker.sv
module fast_row_monitor_checker #(
  parameter int INTR_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              fastEn,
  input logic [INTR_W-1:0] intrErr,
  input logic              fastErr,
  input logic              missErr,
  input logic              rowAbort
);

  AST_ABORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    rowAbort |=> !rowAbort); // R9

  AST_ABORT_WITH_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    rowAbort |-> fastErr); // R9

  AST_MISS_IMPLIES_FAST: assert property (@(posedge clk) disable iff (!rstN)
    missErr |-> fastErr); // R5

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    !fastEn |=> (!fastErr && !missErr)); // R11

  AST_INTR_RAISES: assert property (@(posedge clk) disable iff (!rstN)
    (fastEn && (|intrErr)) |=> fastErr); // R8

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (fastEn && fastErr) |=> fastErr); // R10

endmodule

bind fast_row_monitor fast_row_monitor_checker #(.INTR_W(INTR_W)) u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .fastEn   (fastEn),
  .intrErr  (intrErr),
  .fastErr  (fastErr),
  .missErr  (missErr),
  .rowAbort (rowAbort)
);

// File: tb/fast_row_monitor_test.sv
module fast_row_monitor_test;

  localparam int ADDR_W = 8;
  localparam int ROW_DW = 4;
  localparam int TMO    = 3;
  localparam int INTR_W = 3;

  typedef struct {
    logic  fast;
    logic  miss;
    logic  abort;
    string req;
  } expect_t;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              fastEn = 1'b0;
  logic              wrValid = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic              progDone = 1'b0;
  logic              msTick = 1'b0;
  logic [INTR_W-1:0] intrErr = '0;
  logic              fastErr, missErr, rowAbort;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  expect_t sbQueue[$];

  always #10 clk = ~clk;

  fast_row_monitor #(
    .ADDR_W(ADDR_W), .ROW_DW(ROW_DW), .TIMEOUT_TICKS(TMO), .INTR_W(INTR_W)
  ) uut (
    .clk(clk), .rstN(rstN), .fastEn(fastEn), .wrValid(wrValid), .wrAddr(wrAddr),
    .progDone(progDone), .msTick(msTick), .intrErr(intrErr),
    .fastErr(fastErr), .missErr(missErr), .rowAbort(rowAbort)
  );

  // driver: applies one cycle of stimulus and queues the outputs expected after that edge
  task automatic cyc(input logic en, input logic wv, input logic [ADDR_W-1:0] a,
                     input logic dn, input logic tk, input logic [INTR_W-1:0] ie,
                     input logic eF, input logic eM, input logic eA, input string req);
    expect_t e;
    @(negedge clk);
    fastEn = en; wrValid = wv; wrAddr = a; progDone = dn; msTick = tk; intrErr = ie;
    e.fast = eF; e.miss = eM; e.abort = eA; e.req = req;
    sbQueue.push_back(e);
  endtask

  // monitor: samples away from the edge and compares against the queue
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sbQueue.size() > 0) begin
        expect_t e;
        e = sbQueue.pop_front();
        checks++;
        if (fastErr !== e.fast || missErr !== e.miss || rowAbort !== e.abort) begin
          errors++;
          $display("FAIL %s: got fast=%b miss=%b abort=%b, expected fast=%b miss=%b abort=%b",
                   e.req, fastErr, missErr, rowAbort, e.fast, e.miss, e.abort);
        end
      end
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #35;
    checks++;
    if (fastErr !== 1'b0 || missErr !== 1'b0 || rowAbort !== 1'b0) begin
      errors++;
      $display("FAIL R1: got %b%b%b, expected 000", fastErr, missErr, rowAbort);
    end
    rstN = 1'b1;

    // R2 / R6: full in-order row, final completion is not a miss
    cyc(1, 1, 8'h10, 0, 0, 0, 0, 0, 0, "R2 base write");
    cyc(1, 1, 8'h11, 1, 0, 0, 0, 0, 0, "R2 second");
    cyc(1, 1, 8'h12, 1, 0, 0, 0, 0, 0, "R2 third");
    cyc(1, 1, 8'h13, 1, 0, 0, 0, 0, 0, "R2 fourth");
    cyc(1, 0, 8'h00, 1, 0, 0, 0, 0, 0, "R6 last done");
    cyc(0, 0, 8'h00, 0, 0, 0, 0, 0, 0, "R11 idle");

    // R5 miss, R9 pulse, R10 lock, R11 clear
    cyc(1, 1, 8'h20, 0, 0, 0, 0, 0, 0, "R2 base");
    cyc(1, 0, 8'h00, 1, 0, 0, 1, 1, 1, "R5 miss");
    cyc(1, 0, 8'h00, 0, 0, 0, 1, 1, 0, "R9 pulse ends");
    cyc(1, 1, 8'h21, 0, 0, 0, 1, 1, 0, "R10 write ignored");
    cyc(0, 0, 8'h00, 0, 0, 0, 0, 0, 0, "R11 clear");

    // R3 row crossing, then R10 no miss after lock
    cyc(1, 1, 8'h24, 0, 0, 0, 0, 0, 0, "R2 base");
    cyc(1, 1, 8'h28, 0, 0, 0, 1, 0, 1, "R3 other row");
    cyc(1, 0, 8'h00, 1, 0, 0, 1, 0, 0, "R10 no miss when locked");
    cyc(0, 0, 8'h00, 0, 0, 0, 0, 0, 0, "R11 clear");

    // R4 equal and lower addresses
    cyc(1, 1, 8'h31, 0, 0, 0, 0, 0, 0, "R2 base");
    cyc(1, 1, 8'h31, 0, 0, 0, 1, 0, 1, "R4 equal address");
    cyc(0, 0, 8'h00, 0, 0, 0, 0, 0, 0, "R11 clear");
    cyc(1, 1, 8'h32, 0, 0, 0, 0, 0, 0, "R2 base");
    cyc(1, 1, 8'h31, 0, 0, 0, 1, 0, 1, "R4 lower address");
    cyc(0, 0, 8'h00, 0, 0, 0, 0, 0, 0, "R11 clear");

    // R12 activity while disabled is ignored
    cyc(0, 1, 8'h35, 1, 0, 3'b111, 0, 0, 0, "R12 disabled activity");
    cyc(1, 1, 8'h30, 0, 0, 0, 0, 0, 0, "R12 new base lower");
    cyc(1, 1, 8'h31, 0, 0, 0, 0, 0, 0, "R12 next in order");
    cyc(0, 0, 8'h00, 0, 0, 0, 0, 0, 0, "R11 clear");

    // R7 timeout boundary
    cyc(1, 0, 8'h00, 0, 1, 0, 0, 0, 0, "R7 tick1");
    cyc(1, 0, 8'h00, 0, 1, 0, 0, 0, 0, "R7 tick2");
    cyc(1, 0, 8'h00, 0, 1, 0, 0, 0, 0, "R7 tick3 at limit");
    cyc(1, 0, 8'h00, 0, 1, 0, 1, 0, 1, "R7 tick4 over limit");
    cyc(0, 0, 8'h00, 0, 0, 0, 0, 0, 0, "R11 clear");
    cyc(1, 0, 8'h00, 0, 1, 0, 0, 0, 0, "R11 timer restarted 1");
    cyc(1, 0, 8'h00, 0, 1, 0, 0, 0, 0, "R11 timer restarted 2");
    cyc(1, 0, 8'h00, 0, 1, 0, 0, 0, 0, "R11 timer restarted 3");
    cyc(0, 0, 8'h00, 0, 0, 0, 0, 0, 0, "R11 clear");

    // R8 interrupting error
    cyc(1, 1, 8'h40, 0, 0, 0, 0, 0, 0, "R2 base");
    cyc(1, 0, 8'h00, 0, 0, 3'b010, 1, 0, 1, "R8 interrupt");
    cyc(1, 0, 8'h00, 0, 0, 3'b001, 1, 0, 0, "R10 no second abort");
    cyc(0, 0, 8'h00, 0, 0, 0, 0, 0, 0, "R11 clear");

    cyc(0, 0, 8'h00, 0, 0, 0, 0, 0, 0, "R1 drain");
    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule